// File: doc/BRIEF.md
# Speculative-Load Side Cache Controller

This block manages a small fully associative side cache placed next to a direct-mapped first-level data cache. It accepts one load at a time, each tagged as correct-path or wrong-execution (a load issued down a mispredicted path or by a thread that was later aborted). Wrong-execution loads may only warm the side cache. They never return data and never write the first-level cache, so the speculative work turns into prefetching without touching architectural state.

For correct-path loads the side cache works in two ways. It acts as a victim buffer, taking the line that a first-level fill displaces. It also acts as a next-line prefetch buffer: when a correct-path load hits in the side cache, the two lines are swapped and a fetch of the following line is queued. All next-level traffic goes through a single fetch slot with a fixed, parameterised round-trip time. New loads are held off with a ready signal while that slot is busy.

Lines are modelled as one data word each. Addresses are byte addresses, and the line address is the address with the in-line offset removed.

Top module: `spec_side_cache`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid and mem_req_valid are 0, and both caches are empty, so the first load of any line misses.
- R2: A correct-path load that hits the first-level cache raises rsp_valid one cycle after acceptance, with rsp_l1_hit=1, rsp_side_hit=0 and the stored data. It issues no next-level request.
- R3: A correct-path load that misses both caches issues one next-level request for its line and fills the first-level cache. It responds with rsp_l1_hit=0, rsp_side_hit=0 and the next-level data. A valid displaced first-level line is inserted into the side cache (fill_side).
- R4: A correct-path load that misses the first-level cache but hits the side cache responds one cycle after acceptance with rsp_side_hit=1. The requested line and the first-level victim swap places, and a line is never held in both caches at once.
- R5: After a correct-path side hit on line L, line L+1 is fetched into the side cache on the first idle cycle. The fetch is dropped without a request if L+1 is already in either cache.
- R6: If a demand miss to line L+1 is accepted before that pending fetch is issued, the pending fetch is cancelled and only the demand request goes out.
- R7: A wrong-execution load never produces rsp_valid and never fills the first-level cache. An L1 hit by such a load changes nothing visible.
- R8: A wrong-execution load that misses both caches fetches its line into the side cache only. A later correct-path load of that line then reports a side hit.
- R9: A wrong-execution load that hits the side cache only marks that entry most recently used, and issues no request.
- R10: Side cache replacement uses a free entry first, otherwise the least recently used one. A valid line pushed out is reported on drop_valid/drop_line in the cycle of the insertion.
- R11: Only one next-level request is outstanding. mem_req_valid is a one-cycle pulse, req_ready stays 0 from acceptance of a miss until the fill, and the fill happens MEM_LAT cycles after the request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request present |
| req_wrong | input | 1 | Load is on a wrong path or in an aborted thread |
| req_addr | input | ADDR_W | Load byte address |
| req_ready | output | 1 | Controller can accept a load this cycle |
| rsp_valid | output | 1 | Data returned for a correct-path load |
| rsp_l1_hit | output | 1 | Response came from the first-level cache |
| rsp_side_hit | output | 1 | Response came from the side cache |
| rsp_data | output | DATA_W | Returned line word |
| mem_req_valid | output | 1 | One-cycle next-level fetch request |
| mem_req_line | output | ADDR_W-OFF_W | Line address being fetched |
| mem_rsp_data | input | DATA_W | Next-level data, sampled MEM_LAT cycles after the request |
| fill_l1 | output | 1 | First-level cache written from the next level |
| fill_side | output | 1 | Line inserted into a side cache entry |
| drop_valid | output | 1 | A valid side cache line was pushed out |
| drop_line | output | ADDR_W-OFF_W | Line address pushed out |

## Verification
The delicate overlap is a queued next-line fetch meeting a new demand load in the same idle cycle. The demand must win the lookup port, and a demand miss to the very line being queued must cancel the fetch. The bench provokes this by presenting a correct-path miss to L+1 in the cycle directly after the side hit on L. It then counts next-level request pulses over the following idle cycles and expects exactly one. A second overlap occurs when a first-level fill and the victim insertion into a full side cache land on the same edge. That case is judged through the data returned later and the drop_line address, compared against an LRU order the bench tracks by hand.

// File: rtl/spec_side_pkg.sv
package spec_side_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_WAIT
  } ctl_state_e;

  typedef enum logic [1:0] {
    FK_CORRECT,
    FK_WRONG,
    FK_PREF
  } fetch_kind_e;

endpackage

// File: rtl/spec_side_l1.sv
module spec_side_l1 #(
  parameter int SETS   = 128,
  parameter int LINE_W = 26,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] look_line,
  output logic              hit,
  output logic              vic_valid,
  output logic [LINE_W-1:0] vic_line,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [LINE_W-1:0] wr_line,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = LINE_W - IDX_W;

  logic [SETS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  logic [IDX_W-1:0] look_idx, wr_idx;
  assign look_idx = look_line[IDX_W-1:0];
  assign wr_idx   = wr_line[IDX_W-1:0];

  assign vic_valid = vld_q[look_idx];
  assign vic_line  = {tag_q[look_idx], look_idx};
  assign rd_data   = dat_q[look_idx];
  assign hit       = vic_valid && (tag_q[look_idx] == look_line[LINE_W-1:IDX_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_line[LINE_W-1:IDX_W];
      dat_q[wr_idx] <= wr_data;
    end
  end
endmodule

// File: rtl/spec_side_store.sv
module spec_side_store #(
  parameter int N      = 8,
  parameter int LINE_W = 26,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LINE_W-1:0]    look_line,
  output logic                 hit,
  output logic [$clog2(N)-1:0] hit_idx,
  output logic [DATA_W-1:0]    hit_data,
  output logic [$clog2(N)-1:0] vic_idx,
  output logic                 vic_valid,
  output logic [LINE_W-1:0]    vic_line,
  input  logic                 upd_en,
  input  logic [$clog2(N)-1:0] upd_idx,
  input  logic                 upd_write,
  input  logic                 upd_valid,
  input  logic [LINE_W-1:0]    upd_line,
  input  logic [DATA_W-1:0]    upd_data
);
  localparam int IW = $clog2(N);

  logic [N-1:0]      vld_q;
  logic [IW-1:0]     age_q  [N];
  logic [LINE_W-1:0] line_q [N];
  logic [DATA_W-1:0] dat_q  [N];

  // New age of one entry when entry 'pivot' becomes most recent.
  function automatic logic [IW-1:0] age_after(input logic [IW-1:0] mine,
                                              input logic [IW-1:0] pivot_age,
                                              input logic          is_pivot);
    if (is_pivot)              return '0;
    else if (mine < pivot_age) return mine + IW'(1);
    else                       return mine;
  endfunction

  always_comb begin
    hit = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld_q[i] && line_q[i] == look_line) begin
        hit = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end
  assign hit_data = dat_q[hit_idx];

  always_comb begin
    logic found;
    found = 1'b0;
    vic_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!vld_q[i] && !found) begin
        vic_idx = IW'(i);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++) begin
        if (age_q[i] == IW'(N - 1)) vic_idx = IW'(i);
      end
    end
  end
  assign vic_valid = vld_q[vic_idx];
  assign vic_line  = line_q[vic_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
    end else if (upd_en) begin
      for (int i = 0; i < N; i++)
        age_q[i] <= age_after(age_q[i], age_q[upd_idx], upd_idx == IW'(i));
      if (upd_write) vld_q[upd_idx] <= upd_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en && upd_write) begin
      line_q[upd_idx] <= upd_line;
      dat_q[upd_idx]  <= upd_data;
    end
  end
endmodule

// File: rtl/spec_side_timer.sv
module spec_side_timer #(
  parameter int LAT = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic          run_q;
  logic [CW-1:0] cnt_q;

  assign done = run_q && (cnt_q == CW'(LAT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q) begin
      if (done) run_q <= 1'b0;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/spec_side_cache.sv
module spec_side_cache
  import spec_side_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int L1_BYTES   = 8192,
  parameter int SIDE_N     = 8,
  parameter int MEM_LAT    = 200,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int LINE_W    = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_wrong,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_l1_hit,
  output logic              rsp_side_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_req_valid,
  output logic [LINE_W-1:0] mem_req_line,
  input  logic [DATA_W-1:0] mem_rsp_data,
  output logic              fill_l1,
  output logic              fill_side,
  output logic              drop_valid,
  output logic [LINE_W-1:0] drop_line
);
  localparam int L1_SETS = L1_BYTES / LINE_BYTES;
  localparam int SIW     = $clog2(SIDE_N);

  ctl_state_e  state_q;
  fetch_kind_e kind_q;
  logic [LINE_W-1:0] miss_line_q, pf_line_q;
  logic              pf_pend_q;

  logic [LINE_W-1:0] req_line, look_line;
  logic              unused_offset;
  assign req_line      = req_addr[ADDR_W-1:OFF_W];
  assign unused_offset = ^req_addr[OFF_W-1:0];

  // lookup results
  logic              l1_hit_w, l1_vic_valid;
  logic [LINE_W-1:0] l1_vic_line;
  logic [DATA_W-1:0] l1_rd_data;
  logic              sd_hit_w, sd_vic_valid;
  logic [SIW-1:0]    sd_hit_idx, sd_vic_idx;
  logic [DATA_W-1:0] sd_hit_data;
  logic [LINE_W-1:0] sd_vic_line;

  // named events
  logic accept_w, do_fetch_w, pf_try_w, pf_issue_w, swap_w, wtouch_w;
  logic start_w, mem_done_w, fill_c_w, side_ins_w;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept_w   = req_ready && req_valid;
  assign look_line  = (state_q == ST_WAIT) ? miss_line_q : (req_valid ? req_line : pf_line_q);
  assign do_fetch_w = accept_w && !l1_hit_w && !sd_hit_w;
  assign pf_try_w   = req_ready && !req_valid && pf_pend_q;
  assign pf_issue_w = pf_try_w && !l1_hit_w && !sd_hit_w;
  assign swap_w     = accept_w && !req_wrong && !l1_hit_w && sd_hit_w;
  assign wtouch_w   = accept_w && req_wrong && !l1_hit_w && sd_hit_w;
  assign start_w    = do_fetch_w || pf_issue_w;
  assign fill_c_w   = mem_done_w && (kind_q == FK_CORRECT);
  assign side_ins_w = mem_done_w && ((kind_q != FK_CORRECT) || l1_vic_valid);

  // first-level write port
  logic              l1_wr_en;
  logic [LINE_W-1:0] l1_wr_line;
  logic [DATA_W-1:0] l1_wr_data;
  assign l1_wr_en   = swap_w || fill_c_w;
  assign l1_wr_line = swap_w ? req_line : miss_line_q;
  assign l1_wr_data = swap_w ? sd_hit_data : mem_rsp_data;

  // side cache update port
  logic              sd_upd_en, sd_upd_write, sd_upd_valid;
  logic [SIW-1:0]    sd_upd_idx;
  logic [LINE_W-1:0] sd_upd_line;
  logic [DATA_W-1:0] sd_upd_data;

  always_comb begin
    sd_upd_en    = 1'b0;
    sd_upd_write = 1'b0;
    sd_upd_valid = 1'b1;
    sd_upd_idx   = sd_hit_idx;
    sd_upd_line  = l1_vic_line;
    sd_upd_data  = l1_rd_data;
    if (swap_w) begin
      sd_upd_en    = 1'b1;
      sd_upd_write = 1'b1;
      sd_upd_valid = l1_vic_valid;
    end else if (wtouch_w) begin
      sd_upd_en = 1'b1;
    end else if (side_ins_w) begin
      sd_upd_en    = 1'b1;
      sd_upd_write = 1'b1;
      sd_upd_idx   = sd_vic_idx;
      if (kind_q != FK_CORRECT) begin
        sd_upd_line = miss_line_q;
        sd_upd_data = mem_rsp_data;
      end
    end
  end

  spec_side_l1 #(.SETS(L1_SETS), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_l1 (
    .clk(clk), .rst_n(rst_n), .look_line(look_line),
    .hit(l1_hit_w), .vic_valid(l1_vic_valid), .vic_line(l1_vic_line), .rd_data(l1_rd_data),
    .wr_en(l1_wr_en), .wr_line(l1_wr_line), .wr_data(l1_wr_data)
  );

  spec_side_store #(.N(SIDE_N), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_side (
    .clk(clk), .rst_n(rst_n), .look_line(look_line),
    .hit(sd_hit_w), .hit_idx(sd_hit_idx), .hit_data(sd_hit_data),
    .vic_idx(sd_vic_idx), .vic_valid(sd_vic_valid), .vic_line(sd_vic_line),
    .upd_en(sd_upd_en), .upd_idx(sd_upd_idx), .upd_write(sd_upd_write),
    .upd_valid(sd_upd_valid), .upd_line(sd_upd_line), .upd_data(sd_upd_data)
  );

  spec_side_timer #(.LAT(MEM_LAT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start_w), .done(mem_done_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      kind_q        <= FK_CORRECT;
      miss_line_q   <= '0;
      pf_pend_q     <= 1'b0;
      pf_line_q     <= '0;
      rsp_valid     <= 1'b0;
      rsp_l1_hit    <= 1'b0;
      rsp_side_hit  <= 1'b0;
      rsp_data      <= '0;
      mem_req_valid <= 1'b0;
      mem_req_line  <= '0;
      fill_l1       <= 1'b0;
      fill_side     <= 1'b0;
      drop_valid    <= 1'b0;
      drop_line     <= '0;
    end else begin
      rsp_valid     <= (accept_w && !req_wrong && (l1_hit_w || sd_hit_w)) || fill_c_w;
      rsp_l1_hit    <= accept_w && !req_wrong && l1_hit_w;
      rsp_side_hit  <= swap_w;
      rsp_data      <= fill_c_w ? mem_rsp_data : (l1_hit_w ? l1_rd_data : sd_hit_data);
      mem_req_valid <= start_w;
      fill_l1       <= fill_c_w;
      fill_side     <= side_ins_w;
      drop_valid    <= side_ins_w && sd_vic_valid;
      drop_line     <= sd_vic_line;
      if (start_w) begin
        state_q      <= ST_WAIT;
        kind_q       <= do_fetch_w ? (req_wrong ? FK_WRONG : FK_CORRECT) : FK_PREF;
        miss_line_q  <= look_line;
        mem_req_line <= look_line;
      end else if (mem_done_w) begin
        state_q <= ST_IDLE;
      end
      if (swap_w) begin
        pf_pend_q <= 1'b1;
        pf_line_q <= req_line + LINE_W'(1);
      end else if (pf_try_w || (do_fetch_w && req_line == pf_line_q)) begin
        pf_pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spec_side_cache_chk.sv
module spec_side_cache_chk #(
  parameter int MEM_LAT = 200
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_wrong,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_l1_hit,
  input logic rsp_side_hit,
  input logic mem_req_valid,
  input logic fill_l1,
  input logic fill_side,
  input logic drop_valid,
  input logic l1_hit_w,
  input logic sd_hit_w
);
  logic [31:0] since_req;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  since_req <= '0;
    else if (mem_req_valid)                      since_req <= 32'd1;
    else if (since_req != 0 && since_req < 32'hFFFF_0000) since_req <= since_req + 32'd1;
  end

  p_hit_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_l1_hit && rsp_side_hit));

  p_l1_fill_answers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_l1 |-> rsp_valid && !rsp_l1_hit && !rsp_side_hit);

  p_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_hit_w && sd_hit_w));

  p_wrong_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_wrong) |=> !rsp_valid);

  p_drop_on_insert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    drop_valid |-> fill_side);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);

  p_fill_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_l1 || fill_side) |-> since_req == 32'(MEM_LAT));
endmodule

bind spec_side_cache spec_side_cache_chk #(.MEM_LAT(MEM_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wrong(req_wrong),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_l1_hit(rsp_l1_hit),
  .rsp_side_hit(rsp_side_hit), .mem_req_valid(mem_req_valid), .fill_l1(fill_l1),
  .fill_side(fill_side), .drop_valid(drop_valid), .l1_hit_w(l1_hit_w), .sd_hit_w(sd_hit_w)
);

// File: tb/spec_side_cache_tb_top.sv
`timescale 1ns/1ps
module spec_side_cache_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int LB     = 64;
  localparam int OFF    = 6;
  localparam int LW     = ADDR_W - OFF;
  localparam int LAT    = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_wrong = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_l1_hit, rsp_side_hit;
  logic [DATA_W-1:0] rsp_data, mem_rsp_data;
  logic mem_req_valid, fill_l1, fill_side, drop_valid;
  logic [LW-1:0] mem_req_line, drop_line;

  always #4 clk = ~clk;

  spec_side_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LB), .L1_BYTES(256),
                    .SIDE_N(4), .MEM_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wrong(req_wrong),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_l1_hit(rsp_l1_hit), .rsp_side_hit(rsp_side_hit), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line), .mem_rsp_data(mem_rsp_data),
    .fill_l1(fill_l1), .fill_side(fill_side), .drop_valid(drop_valid), .drop_line(drop_line)
  );

  function automatic logic [31:0] pat(input int ln);
    return (32'(ln) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  int n_chk = 0, n_fail = 0;
  int mreq_cnt = 0, drop_cnt = 0, fl1_cnt = 0, fsd_cnt = 0;
  int last_mreq = 0, last_drop = -1;
  assign mem_rsp_data = pat(last_mreq);

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req_valid) begin mreq_cnt++; last_mreq = int'(mem_req_line); end
      if (drop_valid)    begin drop_cnt++; last_drop = int'(drop_line); end
      if (fill_l1)   fl1_cnt++;
      if (fill_side) fsd_cnt++;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  bit g_valid, g_l1, g_side;
  logic [31:0] g_data;
  int g_lat;

  task automatic load(input int ln, input bit wr);
    req_addr = ADDR_W'(ln << OFF) | ADDR_W'(ln % 7);
    req_wrong = wr;
    req_valid = 1'b1;
    while (!req_ready) tick();
    tick();
    req_valid = 1'b0;
    g_valid = rsp_valid; g_l1 = rsp_l1_hit; g_side = rsp_side_hit; g_data = rsp_data;
    g_lat = 0;
    while (!req_ready && g_lat < 1000) begin
      tick();
      g_lat++;
      if (rsp_valid) begin
        g_valid = 1'b1; g_l1 = rsp_l1_hit; g_side = rsp_side_hit; g_data = rsp_data;
      end
    end
  endtask

  task automatic wait_idle();
    tick();
    while (!req_ready) tick();
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_up();
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 mem_req_valid", mem_req_valid, 0);

    // S1: first load misses everywhere
    load(0, 0);
    chk("R1 first load misses", g_lat, LAT);
    chk("R11 fill latency", g_lat, LAT);
    chk("R3 data", g_data, pat(0));
    chk("R3 no hit flags", {g_l1, g_side}, 0);
    chk("R3 request line", last_mreq, 0);
    chk("R11 one request", mreq_cnt, 1);
    chk("R3 L1 fill", fl1_cnt, 1);

    // S2: L1 hit
    load(0, 0);
    chk("R2 valid", g_valid, 1);
    chk("R2 l1 flag", g_l1, 1);
    chk("R2 side flag", g_side, 0);
    chk("R2 data", g_data, pat(0));
    chk("R2 no request", mreq_cnt, 1);

    // wrong-path L1 hit
    load(0, 1);
    chk("R7 no response on L1 hit", g_valid, 0);
    chk("R7 no request", mreq_cnt, 1);

    // S3: conflict miss, victim 0 into side
    load(4, 0);
    chk("R3 data line 4", g_data, pat(4));
    chk("R3 victim to side", fsd_cnt, 1);

    // S4: side hit and swap
    load(0, 0);
    chk("R4 side flag", g_side, 1);
    chk("R4 data", g_data, pat(0));
    chk("R4 no request", mreq_cnt, 2);
    wait_idle();
    chk("R5 next line fetched", mreq_cnt, 3);
    chk("R5 next line address", last_mreq, 1);

    // S6/S7: side hit, then demand for the queued line in the next cycle
    load(1, 0);
    chk("R5 prefetched line hits side", g_side, 1);
    chk("R5 prefetched data", g_data, pat(1));
    load(2, 0);
    chk("R6 demand data", g_data, pat(2));
    repeat (10) tick();
    chk("R6 queued fetch cancelled", mreq_cnt, 4);

    load(3, 0);
    load(6, 0);
    chk("R3 requests so far", mreq_cnt, 6);
    load(2, 0);
    chk("R4 swap back data", g_data, pat(2));
    chk("R4 swap back flag", g_side, 1);
    repeat (4) tick();
    chk("R5 fetch dropped, next line in L1", mreq_cnt, 6);
    chk("R5 ready after drop", req_ready, 1);

    // S11: wrong-path miss fills side only
    load(9, 1);
    chk("R7 no response on miss", g_valid, 0);
    chk("R7 no L1 fill", fl1_cnt, 5);
    chk("R8 fetched", last_mreq, 9);
    chk("R8 latency", g_lat, LAT);
    load(9, 0);
    chk("R8 later load hits side", g_side, 1);
    chk("R8 data", g_data, pat(9));
    wait_idle();
    chk("R5 fetch of line 10", last_mreq, 10);
    chk("R10 no drop before side full", drop_cnt, 0);

    // S13/S14: wrong-path side hit protects line 4
    load(4, 1);
    chk("R9 no response", g_valid, 0);
    chk("R9 no request", mreq_cnt, 8);
    load(13, 1);
    chk("R10 drop count", drop_cnt, 1);
    chk("R10 LRU line dropped", last_drop, 6);
    load(4, 0);
    chk("R9 touched line survived", g_side, 1);
    chk("R9 data", g_data, pat(4));
    load(6, 0);
    chk("R10 dropped line misses", g_lat, LAT);
    chk("R10 refetched data", g_data, pat(6));
    chk("R10 victim insert drop", last_drop, 1);
    wait_idle();
    chk("R6 queued fetch kept for other line", last_mreq, 5);
    chk("R10 third drop", drop_cnt, 3);
    chk("R10 third drop line", last_drop, 10);
    load(5, 0);
    chk("R5 line 5 in side", g_side, 1);
    chk("R5 line 5 data", g_data, pat(5));

    finish_up();
  end
endmodule